// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block gives a host processor access to a small bank of internal registers over one of two shared-pin links. A mode strap selects the link: a parallel bus with chip select, read/write line, address bus and two active-low byte-write enables, or a four-wire SPI-style serial link. The serial link reuses the byte-enable pins as serial clock and serial data in, the read/write pin as a clock-phase select and data pin 0 as serial data out. In parallel mode a second strap sets the data bus to 32 or 16 bits.

Every host pin passes through a two-flop synchronizer into the internal clock, so the host may run fully asynchronously. The serial link has no select line. Frame boundaries are therefore recovered from clock silence: any serial clock edge that follows a long enough gap begins a new frame. Register 0 holds a fixed identification word. The other registers are scratch storage that software uses to test the path.

Top module: `host_reg_if`

## Requirements
- R1: `mode_par_i` low selects the serial link and high selects the parallel bus. In serial mode only pad 0 is driven (`data_oe_o` equals 32'h1), and `cs_ni`, `wide_i`, `addr_i` and `data_i` have no effect.
- R2: With `wide_i` low (16-bit), only `data_i[15:0]` is used. `addr_i[0]` (address bit 1) selects the low (0) or high (1) half of the word. Reads return the half on `data_o[15:0]` with zeros above, and `data_oe_o[31:16]` stays 0.
- R3: With `wide_i` high (32-bit), `addr_i[23:1]` (address bits 24..2) selects a word and all 32 data bits are transferred.
- R4: In both widths a write updates lane byte 0 only when `be0_ni` is 0 and lane byte 1 only when `be1_ni` is 0. In 16-bit mode these lanes are bytes 0 and 1 of the selected half.
- R5: In 32-bit mode a write always updates bytes 2 and 3.
- R6: In parallel mode nothing is written while `cs_ni` is high. A parallel write needs `cs_ni` low and `rnw_i` low (`rnw_i` high means read).
- R7: A parallel write commits exactly once per chip-select assertion, using the bus values seen in the first synchronized cycle with `cs_ni` low. Later changes while `cs_ni` stays low are ignored.
- R8: In parallel mode the data pads are driven only while `cs_ni` is low and `rnw_i` is high. All 32 pads are driven in 32-bit mode and only pads 15..0 in 16-bit mode. Otherwise `data_oe_o` is 0.
- R9: A serial frame is 40 bits, MSB first: a read flag (1 read, 0 write), a 23-bit halfword address (bit 0 picks the half, bits 22..1 the word), then 16 data bits. A write commits after the 40th bit. On a read, the addressed half is shifted out MSB first during the 16 data-bit slots.
- R10: The serial clock idles low. With `rnw_i` low, input is sampled on the rising edge and output changes on the falling edge. With `rnw_i` high, input is sampled on the falling edge and output changes on the rising edge.
- R11: A serial clock edge that follows more than `IDLE_CYC` internal cycles without any edge starts a new frame and abandons any partial frame.
- R12: Register 0 reads `ID_VALUE` and ignores writes. Registers 1 to `NUM_WORDS`-1 are read/write and reset to 0.
- R13: Reads of a word index at or above `NUM_WORDS` return 0, and writes to such an index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_par_i | input | 1 | Link strap: 1 parallel, 0 serial |
| wide_i | input | 1 | Parallel width strap: 1 32-bit, 0 16-bit |
| addr_i | input | 24 | Host address bits 24..1 |
| cs_ni | input | 1 | Parallel chip select, active low |
| rnw_i | input | 1 | Parallel: 1 read, 0 write. Serial: clock-phase select |
| be0_ni | input | 1 | Parallel: byte 0 write enable, active low. Serial: clock |
| be1_ni | input | 1 | Parallel: byte 1 write enable, active low. Serial: data in |
| data_i | input | 32 | Data pad inputs |
| data_o | output | 32 | Data pad outputs; bit 0 is serial data out in serial mode |
| data_oe_o | output | 32 | Per-pad output enable |

## Verification
The bench builds the block with `NUM_WORDS`=4, so a short address such as word 7 falls outside the bank and exercises the zero-read and dropped-write path. It sets `IDLE_CYC`=16, so that frame resynchronization after an abandoned partial frame takes a few dozen cycles. With a serial half-period of 5 cycles, both clock phases stay below the timeout, and the serial data out has settled before the host samples it. `ID_VALUE` is given a distinct value so that reads of both halves of register 0 can be told apart.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned BYTES     = WORD_W / 8;
  localparam int unsigned PADDR_W   = 24;
  localparam int unsigned SADDR_W   = 23;
  localparam int unsigned IDX_W     = PADDR_W - 1;
  localparam int unsigned ADDR_END  = 1 + SADDR_W;
  localparam int unsigned FRAME_LEN = ADDR_END + HALF_W;

  typedef struct packed {
    logic               en;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  data;
    logic [BYTES-1:0]   mask;
  } wr_t;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int unsigned   W   = 1,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/host_reg_file.sv
module host_reg_file
  import host_reg_pkg::*;
#(
  parameter int unsigned       NUM_WORDS = 4,
  parameter logic [WORD_W-1:0] ID_VALUE  = 32'h5A17_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_t               wr_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [WORD_W-1:0] rd_a_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [WORD_W-1:0] rd_b_o
);
  localparam int unsigned SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (w == 0) begin : g_id
      assign words[w] = ID_VALUE;
    end else begin : g_rw
      logic [WORD_W-1:0] q_r;
      logic              hit;
      assign hit = wr_i.en && (wr_i.idx == IDX_W'(w));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_r <= '0;
        end else if (hit) begin
          for (int b = 0; b < BYTES; b++) begin
            if (wr_i.mask[b]) q_r[8*b +: 8] <= wr_i.data[8*b +: 8];
          end
        end
      end
      assign words[w] = q_r;
    end
  end

  assign rd_a_o = (rd_a_idx_i < IDX_W'(NUM_WORDS)) ? words[rd_a_idx_i[SEL_W-1:0]] : '0;
  assign rd_b_o = (rd_b_idx_i < IDX_W'(NUM_WORDS)) ? words[rd_b_idx_i[SEL_W-1:0]] : '0;
endmodule

// File: rtl/host_spi_engine.sv
module host_spi_engine
  import host_reg_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic               cpha_i,
  input  logic [HALF_W-1:0]  rd_half_i,
  output logic [SADDR_W-1:0] addr_o,
  output wr_t                wr_o,
  output logic               miso_o,
  output logic               upd_o
);
  localparam int unsigned IW = $clog2(IDLE_CYC + 1);
  localparam int unsigned CW = $clog2(FRAME_LEN + 1);

  logic               sclk_d, rise, fall, samp_e, upd_e, stale;
  logic [IW-1:0]      idle_q;
  logic [CW-1:0]      cnt_q, eff_cnt;
  logic [SADDR_W-1:0] sh_q, addr_q;
  logic [HALF_W-1:0]  wdat_q;
  logic               rw_q, wr_en_q, miso_q;

  assign rise   = sclk_i & ~sclk_d;
  assign fall   = ~sclk_i & sclk_d;
  assign samp_e = en_i & (cpha_i ? fall : rise);
  assign upd_e  = en_i & (cpha_i ? rise : fall);
  assign stale  = (idle_q == IW'(IDLE_CYC));
  assign eff_cnt = stale ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      idle_q <= IW'(IDLE_CYC);
    end else begin
      sclk_d <= sclk_i;
      if (samp_e || upd_e) idle_q <= '0;
      else if (!stale)     idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rw_q    <= 1'b0;
      wr_en_q <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (samp_e) begin
        if (eff_cnt < CW'(FRAME_LEN)) cnt_q <= eff_cnt + 1'b1;
        if (eff_cnt == '0) begin
          rw_q <= mosi_i;
        end else if (eff_cnt < CW'(FRAME_LEN)) begin
          sh_q <= {sh_q[SADDR_W-2:0], mosi_i};
          if (eff_cnt == CW'(ADDR_END - 1)) addr_q <= {sh_q[SADDR_W-2:0], mosi_i};
          if (eff_cnt == CW'(FRAME_LEN - 1) && !rw_q) begin
            wr_en_q <= 1'b1;
            wdat_q  <= {sh_q[HALF_W-2:0], mosi_i};
          end
        end
      end else if (upd_e) begin
        if (stale) begin
          cnt_q <= '0;
        end else if (rw_q && cnt_q >= CW'(ADDR_END) && cnt_q < CW'(FRAME_LEN)) begin
          // data slot k carries half bit 15-k
          miso_q <= rd_half_i[4'(CW'(FRAME_LEN - 1) - cnt_q)];
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_o.en   = wr_en_q;
  assign wr_o.idx  = IDX_W'(addr_q[SADDR_W-1:1]);
  assign wr_o.data = addr_q[0] ? {wdat_q, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, wdat_q};
  assign wr_o.mask = addr_q[0] ? 4'b1100 : 4'b0011;
  assign miso_o    = miso_q;
  assign upd_o     = upd_e;
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
  import host_reg_pkg::*;
#(
  parameter int unsigned       NUM_WORDS = 4,
  parameter logic [WORD_W-1:0] ID_VALUE  = 32'h5A17_0001,
  parameter int unsigned       IDLE_CYC  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_par_i,
  input  logic               wide_i,
  input  logic [PADDR_W-1:0] addr_i,
  input  logic               cs_ni,
  input  logic               rnw_i,
  input  logic               be0_ni,
  input  logic               be1_ni,
  input  logic [WORD_W-1:0]  data_i,
  output logic [WORD_W-1:0]  data_o,
  output logic [WORD_W-1:0]  data_oe_o
);
  localparam int unsigned CTL_W = 6;
  localparam int unsigned BUS_W = PADDR_W + WORD_W;

  logic [CTL_W-1:0]   ctl_s;
  logic [BUS_W-1:0]   bus_s;
  logic               mode_s, wide_s, cs_s, rnw_s, be0_s, be1_s;
  logic [PADDR_W-1:0] addr_s;
  logic [WORD_W-1:0]  data_s;

  // straps default to parallel (pull-up); controls idle inactive
  host_sync #(.W(CTL_W), .RST(6'b101111)) u_sync_ctl (
    .clk_i, .rst_ni,
    .d_i ({mode_par_i, wide_i, cs_ni, rnw_i, be0_ni, be1_ni}),
    .q_o (ctl_s)
  );
  host_sync #(.W(BUS_W), .RST('0)) u_sync_bus (
    .clk_i, .rst_ni,
    .d_i ({addr_i, data_i}),
    .q_o (bus_s)
  );
  assign {mode_s, wide_s, cs_s, rnw_s, be0_s, be1_s} = ctl_s;
  assign {addr_s, data_s} = bus_s;

  // parallel side
  logic par_act, par_we, done_q;
  wr_t  par_wr, spi_wr, wr_mux;

  assign par_act = mode_s & ~cs_s;
  assign par_we  = par_act & ~rnw_s & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= par_act;
  end

  always_comb begin
    par_wr.en  = par_we;
    par_wr.idx = addr_s[PADDR_W-1:1];
    if (wide_s) begin
      par_wr.data = data_s;
      par_wr.mask = {2'b11, ~be1_s, ~be0_s};
    end else if (addr_s[0]) begin
      par_wr.data = {data_s[HALF_W-1:0], {HALF_W{1'b0}}};
      par_wr.mask = {~be1_s, ~be0_s, 2'b00};
    end else begin
      par_wr.data = {{HALF_W{1'b0}}, data_s[HALF_W-1:0]};
      par_wr.mask = {2'b00, ~be1_s, ~be0_s};
    end
  end

  // serial side
  logic [SADDR_W-1:0] spi_addr;
  logic [WORD_W-1:0]  rd_a, rd_b;
  logic [HALF_W-1:0]  spi_half;
  logic               miso, spi_upd, spi_we;

  assign spi_half = spi_addr[0] ? rd_b[WORD_W-1:HALF_W] : rd_b[HALF_W-1:0];

  host_spi_engine #(.IDLE_CYC(IDLE_CYC)) u_spi (
    .clk_i, .rst_ni,
    .en_i      (~mode_s),
    .sclk_i    (be0_s),
    .mosi_i    (be1_s),
    .cpha_i    (rnw_s),
    .rd_half_i (spi_half),
    .addr_o    (spi_addr),
    .wr_o      (spi_wr),
    .miso_o    (miso),
    .upd_o     (spi_upd)
  );
  assign spi_we = spi_wr.en;

  assign wr_mux = mode_s ? par_wr : spi_wr;

  host_reg_file #(.NUM_WORDS(NUM_WORDS), .ID_VALUE(ID_VALUE)) u_rf (
    .clk_i, .rst_ni,
    .wr_i       (wr_mux),
    .rd_a_idx_i (addr_s[PADDR_W-1:1]),
    .rd_a_o     (rd_a),
    .rd_b_idx_i (IDX_W'(spi_addr[SADDR_W-1:1])),
    .rd_b_o     (rd_b)
  );

  // pads
  logic par_rd;
  assign par_rd = par_act & rnw_s;

  always_comb begin
    if (!mode_s) begin
      data_o    = {{(WORD_W-1){1'b0}}, miso};
      data_oe_o = {{(WORD_W-1){1'b0}}, 1'b1};
    end else if (wide_s) begin
      data_o    = rd_a;
      data_oe_o = {WORD_W{par_rd}};
    end else begin
      data_o    = {{HALF_W{1'b0}}, addr_s[0] ? rd_a[WORD_W-1:HALF_W] : rd_a[HALF_W-1:0]};
      data_oe_o = {{HALF_W{1'b0}}, {HALF_W{par_rd}}};
    end
  end
endmodule

// File: rtl/host_reg_if_chk.sv
module host_reg_if_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_s,
  input logic        wide_s,
  input logic        cs_s,
  input logic        rnw_s,
  input logic [31:0] data_oe_o,
  input logic        par_we,
  input logic        spi_we,
  input logic        spi_upd,
  input logic        miso
);
  // R1
  spi_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s |-> data_oe_o == 32'h1);

  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && data_oe_o != '0) |-> (!cs_s && rnw_s));

  // R2
  narrow_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && !wide_s) |-> data_oe_o[31:16] == 16'h0);

  // R6
  par_we_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_we |-> (mode_s && !cs_s && !rnw_s));

  // R7
  one_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_we |=> !par_we);

  // R9
  spi_we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_we |=> !spi_we);

  // R10
  miso_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_upd |=> $stable(miso));
endmodule

bind host_reg_if host_reg_if_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_s    (mode_s),
  .wide_s    (wide_s),
  .cs_s      (cs_s),
  .rnw_s     (rnw_s),
  .data_oe_o (data_oe_o),
  .par_we    (par_we),
  .spi_we    (spi_we),
  .spi_upd   (spi_upd),
  .miso      (miso)
);

// File: tb/host_reg_if_tb.sv
module host_reg_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 5;
  localparam int GAP        = 40;
  localparam logic [31:0] ID = 32'h5A17_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_par = 1'b1, wide = 1'b1, cs_n = 1'b1, rnw = 1'b1;
  logic        be0_n = 1'b1, be1_n = 1'b1;
  logic [23:0] addr = '0;
  logic [31:0] data_in = '0;
  logic [31:0] data_out, data_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reg_if #(.NUM_WORDS(4), .ID_VALUE(ID), .IDLE_CYC(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_par_i(mode_par), .wide_i(wide),
    .addr_i(addr), .cs_ni(cs_n), .rnw_i(rnw), .be0_ni(be0_n), .be1_ni(be1_n),
    .data_i(data_in), .data_o(data_out), .data_oe_o(data_oe)
  );

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t        sbq[$];
  event        obs_ev;
  logic [31:0] obs_val;
  int          checks = 0, errors = 0;
  bit          done = 0;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: queue expectation
  task automatic expect_val(string tag, logic [31:0] v);
    exp_t e;
    e.tag = tag; e.exp = v;
    sbq.push_back(e);
  endtask

  task automatic observe(logic [31:0] v);
    obs_val = v;
    ->obs_ev;
    #1;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      exp_t e;
      @(obs_ev);
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard-empty: actual=%h expected=none", obs_val);
      end else begin
        e = sbq.pop_front();
        if (obs_val !== e.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, obs_val, e.exp);
        end
      end
    end
  end

  task automatic par_write(logic [23:0] a, logic [31:0] d, logic b0, logic b1);
    addr = a; data_in = d; rnw = 1'b0; be0_n = b0; be1_n = b1;
    wait_n(3);
    cs_n = 1'b0;
    wait_n(5);
    cs_n = 1'b1;
    wait_n(1);
    rnw = 1'b1; be0_n = 1'b1; be1_n = 1'b1;
    wait_n(4);
  endtask

  task automatic par_read(logic [23:0] a, output logic [31:0] d, output logic [31:0] oe);
    addr = a; rnw = 1'b1;
    wait_n(3);
    cs_n = 1'b0;
    wait_n(5);
    d = data_out; oe = data_oe;
    cs_n = 1'b1;
    wait_n(4);
  endtask

  // serial master: clock on be0_n, data on be1_n, phase on rnw
  task automatic spi_xfer(logic cpha, logic [39:0] frame, int nbits, output logic [15:0] rd);
    rd = '0;
    rnw = cpha; be0_n = 1'b0;
    wait_n(GAP);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        be1_n = frame[39-i];
        wait_n(HALF_SCK);
        if (i >= 24) rd = {rd[14:0], data_out[0]};
        be0_n = 1'b1;
        wait_n(HALF_SCK);
        be0_n = 1'b0;
      end else begin
        be0_n = 1'b1;
        be1_n = frame[39-i];
        wait_n(HALF_SCK);
        if (i >= 24) rd = {rd[14:0], data_out[0]};
        be0_n = 1'b0;
        wait_n(HALF_SCK);
      end
    end
    wait_n(GAP);
  endtask

  task automatic spi_wr(logic cpha, logic [22:0] a, logic [15:0] d);
    logic [15:0] dummy;
    spi_xfer(cpha, {1'b0, a, d}, 40, dummy);
  endtask

  task automatic spi_rd(logic cpha, logic [22:0] a, output logic [15:0] d);
    spi_xfer(cpha, {1'b1, a, 16'h0}, 40, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, oe;
    logic [15:0] srd;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // reset state
    expect_val("R8 reset oe", 32'h0); observe(data_oe);
    par_read(24'h0, rd, oe);
    expect_val("R12 id word", ID); observe(rd);
    par_read(24'h4, rd, oe);
    expect_val("R12 scratch reset", 32'h0); observe(rd);

    // 32-bit mode
    par_write(24'h2, 32'h1122_3344, 1'b0, 1'b0);
    par_read(24'h2, rd, oe);
    expect_val("R3 word write", 32'h1122_3344); observe(rd);
    expect_val("R8 oe wide read", 32'hFFFF_FFFF); observe(oe);
    expect_val("R8 oe after cs", 32'h0); observe(data_oe);

    par_write(24'h2, 32'hAAAA_BBCC, 1'b0, 1'b1);
    par_read(24'h2, rd, oe);
    expect_val("R4 R5 byte gating", 32'hAAAA_33CC); observe(rd);

    // R6: write cycle without chip select
    addr = 24'h2; data_in = 32'hFFFF_FFFF; rnw = 1'b0; be0_n = 1'b0; be1_n = 1'b0;
    wait_n(10);
    expect_val("R6 no cs oe", 32'h0); observe(data_oe);
    rnw = 1'b1; be0_n = 1'b1; be1_n = 1'b1;
    wait_n(4);
    par_read(24'h2, rd, oe);
    expect_val("R6 no cs write", 32'hAAAA_33CC); observe(rd);

    // R7: data change while cs held low
    addr = 24'h2; data_in = 32'h0101_0202; rnw = 1'b0; be0_n = 1'b0; be1_n = 1'b0;
    wait_n(3);
    cs_n = 1'b0;
    wait_n(5);
    data_in = 32'hFFFF_0000;
    wait_n(5);
    cs_n = 1'b1;
    wait_n(1);
    rnw = 1'b1; be0_n = 1'b1; be1_n = 1'b1;
    wait_n(4);
    par_read(24'h2, rd, oe);
    expect_val("R7 single commit", 32'h0101_0202); observe(rd);

    par_write(24'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    par_read(24'h0, rd, oe);
    expect_val("R12 id read-only", ID); observe(rd);

    par_write(24'hE, 32'h1234_5678, 1'b0, 1'b0);
    par_read(24'hE, rd, oe);
    expect_val("R13 out of range", 32'h0); observe(rd);

    // 16-bit mode
    wide = 1'b0;
    wait_n(4);
    par_write(24'h4, 32'hDEAD_1234, 1'b0, 1'b0);
    par_write(24'h5, 32'h0000_5678, 1'b0, 1'b0);
    par_read(24'h4, rd, oe);
    expect_val("R2 low half", 32'h0000_1234); observe(rd);
    expect_val("R2 narrow oe", 32'h0000_FFFF); observe(oe);
    par_write(24'h5, 32'h0000_9900, 1'b1, 1'b0);
    par_read(24'h5, rd, oe);
    expect_val("R4 narrow byte gating", 32'h0000_9978); observe(rd);
    wide = 1'b1;
    wait_n(4);
    par_read(24'h4, rd, oe);
    expect_val("R2 upper pins ignored", 32'h9978_1234); observe(rd);

    // serial mode
    be0_n = 1'b0; rnw = 1'b0;
    mode_par = 1'b0;
    wait_n(6);
    expect_val("R1 serial oe", 32'h1); observe(data_oe);

    spi_wr(1'b0, 23'd6, 16'hBEEF);
    spi_rd(1'b0, 23'd6, srd);
    expect_val("R9 R10 phase0 readback", 32'h0000_BEEF); observe({16'h0, srd});
    spi_rd(1'b0, 23'd5, srd);
    expect_val("R9 high half read", 32'h0000_9978); observe({16'h0, srd});

    spi_wr(1'b1, 23'd7, 16'hCAFE);
    spi_rd(1'b1, 23'd7, srd);
    expect_val("R10 phase1 readback", 32'h0000_CAFE); observe({16'h0, srd});
    spi_rd(1'b1, 23'd1, srd);
    expect_val("R12 id high via serial", 32'h0000_5A17); observe({16'h0, srd});

    // R11: partial frame abandoned after idle
    spi_xfer(1'b1, {1'b0, 23'd6, 16'h0000}, 10, srd);
    spi_rd(1'b1, 23'd6, srd);
    expect_val("R11 resync", 32'h0000_BEEF); observe({16'h0, srd});

    // back to parallel
    mode_par = 1'b1; rnw = 1'b1; be0_n = 1'b1; be1_n = 1'b1;
    wait_n(6);
    par_read(24'h6, rd, oe);
    expect_val("R9 serial writes visible", 32'hCAFE_BEEF); observe(rd);

    if (sbq.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard-leftover: actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule